// File: doc/BRIEF.md
# Accelerator Control and Status Register

This block is the 32-bit control and status word of a multi-engine crypto accelerator. Software reaches it through a simple register port: a write strobe with a data word, and a read word that always shows the current state. The word holds the accelerator's selects and enables, a self-clearing soft reset, and the completion state of each engine. It also holds a sticky bus-error flag, an aggregate done bit, a ready bit and a level interrupt.

The engines report completion with one-cycle pulses on their done inputs. The math engine instead reports a start/complete level, and the DMA reports bus errors as pulses. A one-way flag-mode latch changes how the engine done flags respond to writes. When it is clear, software writes the flags directly. Once it is set, a 1 clears a flag and a 0 leaves it alone. A separate select bit decides whether DMA completion takes part in the aggregate done bit and the interrupt.

Top module: `acsr_top`

## Requirements
- R1: Writing a word with bit 0 set makes bit 0 and `soft_rst_o` read 1 for exactly one cycle after the write, after which both return to 0. A write made while the soft reset is already active does not extend it.
- R2: Configuration bits are held through a soft reset and are replaced only by a register write: interrupt enable (bit 1), input source (2), output swap (3), input swap (4), wait enable (5), wait polarity (6), write-source field (8:7), read-source field (10:9) and DMA-done select (12). The matching output pins follow these bits.
- R3: While flag mode (bit 11) is 0, a write loads bits 27:24 (27 DMA, 26 Galois/CRC, 25 hash, 24 cipher) with the written value, whether 0 or 1.
- R4: While flag mode is 1, writing 1 to a flag bit in 27:24 clears that flag and writing 0 leaves it unchanged.
- R5: Writing 1 to bit 11 sets flag mode. Writing 0 does not clear it. Only a hardware reset or a soft reset clears it.
- R6: An engine done pulse sets its flag on the next edge, and it wins over a software clear or a soft reset in the same cycle.
- R7: A DMA bus-error pulse sets the error flag (bit 29) and `dma_stop_o` on the next edge. Register writes do not clear it. A soft reset clears it, unless a new error pulse arrives in the same cycle.
- R8: Bit 31 is the OR of the cipher, hash, Galois and math-engine done flags, together with the DMA flag only when DMA-done select (bit 12) is 1.
- R9: `irq_o` is 1 exactly when interrupt enable is 1 and either bit 31 or bit 29 is 1, with no added delay.
- R10: Bit 23 reads the inverse of `maa_stc_i`. Writes to it have no effect.
- R11: Bit 30 reads the inverse of `busy_i`. Bits 28 and 22:13 always read 0.
- R12: After a hardware reset, every stored bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Current register word |
| cph_done_i | input | 1 | Cipher completion pulse |
| hsh_done_i | input | 1 | Hash completion pulse |
| gls_done_i | input | 1 | Galois/CRC completion pulse |
| dma_done_i | input | 1 | DMA completion pulse |
| maa_stc_i | input | 1 | Math engine start/complete level |
| dma_bus_err_i | input | 1 | DMA bus error pulse |
| busy_i | input | 1 | Accelerator busy |
| soft_rst_o | output | 1 | One-cycle internal reset to the engines |
| irq_o | output | 1 | Level interrupt |
| dma_stop_o | output | 1 | Halts the DMA while the error flag is set |
| src_sel_o | output | 1 | Hash/CRC input source select |
| swap_in_o | output | 1 | Input byte swap enable |
| swap_out_o | output | 1 | Output byte swap enable |
| wait_en_o | output | 1 | External wait pin enable |
| wait_pol_o | output | 1 | External wait pin polarity |
| wr_src_o | output | 2 | Write-FIFO source select |
| rd_src_o | output | 2 | Read-FIFO source select |

## Verification
Writes, done pulses and error pulses take effect at the next clock edge, so they show on the read word one cycle later. Bit 23, bit 30, bit 31 and the interrupt are combinational from state and pins, so they are valid in the same cycle. The bench drives inputs on the falling edge, holds them through the rising edge, and then updates its own model of the word. It compares at the following falling edge, before any input changes. The one-cycle life of the soft reset is therefore seen as exactly one sample of 1 followed by a 0.

// File: rtl/acsr_pkg.sv
package acsr_pkg;

    localparam int REG_W     = 32;
    localparam int NUM_FLAGS = 4;

    localparam int B_RST     = 0;
    localparam int B_IEN     = 1;
    localparam int B_SRC     = 2;
    localparam int B_SWO     = 3;
    localparam int B_SWI     = 4;
    localparam int B_WEN     = 5;
    localparam int B_WPOL    = 6;
    localparam int B_WRSRC   = 7;
    localparam int B_RDSRC   = 9;
    localparam int B_FMODE   = 11;
    localparam int B_DSEL    = 12;
    localparam int B_MAA     = 23;
    localparam int B_FLAGS   = 24;
    localparam int B_ERR     = 29;
    localparam int B_RDY     = 30;
    localparam int B_DONE    = 31;

    typedef enum logic [1:0] {
        FL_CPH = 2'd0,
        FL_HSH = 2'd1,
        FL_GLS = 2'd2,
        FL_DMA = 2'd3
    } flag_idx_e;

    typedef struct packed {
        logic       dma_sel;
        logic [1:0] rd_src;
        logic [1:0] wr_src;
        logic       wait_pol;
        logic       wait_en;
        logic       swap_in;
        logic       swap_out;
        logic       src_sel;
        logic       irq_en;
    } cfg_t;

    function automatic cfg_t cfg_unpack(input logic [REG_W-1:0] w);
        cfg_t c;
        c.irq_en   = w[B_IEN];
        c.src_sel  = w[B_SRC];
        c.swap_out = w[B_SWO];
        c.swap_in  = w[B_SWI];
        c.wait_en  = w[B_WEN];
        c.wait_pol = w[B_WPOL];
        c.wr_src   = w[B_WRSRC +: 2];
        c.rd_src   = w[B_RDSRC +: 2];
        c.dma_sel  = w[B_DSEL];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] cfg_pack(input cfg_t c);
        logic [REG_W-1:0] w;
        w              = '0;
        w[B_IEN]       = c.irq_en;
        w[B_SRC]       = c.src_sel;
        w[B_SWO]       = c.swap_out;
        w[B_SWI]       = c.swap_in;
        w[B_WEN]       = c.wait_en;
        w[B_WPOL]      = c.wait_pol;
        w[B_WRSRC +: 2] = c.wr_src;
        w[B_RDSRC +: 2] = c.rd_src;
        w[B_DSEL]      = c.dma_sel;
        return w;
    endfunction

endpackage

// File: rtl/acsr_cfg.sv
module acsr_cfg
    import acsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [B_DSEL:0]  wbits,
    output cfg_t             cfg,
    output logic             flag_mode,
    output logic             soft_rst
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg       <= '0;
            flag_mode <= 1'b0;
            soft_rst  <= 1'b0;
        end else begin
            soft_rst <= wr & wbits[B_RST] & ~soft_rst;
            if (wr) begin
                cfg <= cfg_unpack({{(REG_W-B_DSEL-1){1'b0}}, wbits});
            end
            if (soft_rst) begin
                flag_mode <= 1'b0;
            end else if (wr && wbits[B_FMODE]) begin
                flag_mode <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/acsr_flags.sv
module acsr_flags
    import acsr_pkg::*;
#(
    parameter int N = NUM_FLAGS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_pulse,
    input  logic         wr,
    input  logic [N-1:0] wval,
    input  logic         w1c_mode,
    input  logic         clr_all,
    output logic [N-1:0] flags
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                flags[i] <= 1'b0;
            end else if (set_pulse[i]) begin
                flags[i] <= 1'b1;
            end else if (clr_all) begin
                flags[i] <= 1'b0;
            end else if (wr) begin
                flags[i] <= w1c_mode ? (flags[i] & ~wval[i]) : wval[i];
            end
        end
    end

endmodule

// File: rtl/acsr_stat.sv
module acsr_stat
    import acsr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_err,
    input  logic                 soft_rst,
    input  logic [NUM_FLAGS-1:0] flags,
    input  logic                 maa_done,
    input  logic                 dma_sel,
    input  logic                 irq_en,
    output logic                 err,
    output logic                 agg_done,
    output logic                 irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            err <= 1'b0;
        end else if (bus_err) begin
            err <= 1'b1;
        end else if (soft_rst) begin
            err <= 1'b0;
        end
    end

    always_comb begin
        agg_done = flags[FL_CPH] | flags[FL_HSH] | flags[FL_GLS] | maa_done
                 | (flags[FL_DMA] & dma_sel);
        irq      = irq_en & (agg_done | err);
    end

endmodule

// File: rtl/acsr_top.sv
module acsr_top
    import acsr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr_i,
    input  logic [31:0] reg_wdata_i,
    output logic [31:0] reg_rdata_o,
    input  logic        cph_done_i,
    input  logic        hsh_done_i,
    input  logic        gls_done_i,
    input  logic        dma_done_i,
    input  logic        maa_stc_i,
    input  logic        dma_bus_err_i,
    input  logic        busy_i,
    output logic        soft_rst_o,
    output logic        irq_o,
    output logic        dma_stop_o,
    output logic        src_sel_o,
    output logic        swap_in_o,
    output logic        swap_out_o,
    output logic        wait_en_o,
    output logic        wait_pol_o,
    output logic [1:0]  wr_src_o,
    output logic [1:0]  rd_src_o
);

    cfg_t                 cfg;
    logic                 flag_mode;
    logic                 soft_rst;
    logic [NUM_FLAGS-1:0] flags;
    logic [NUM_FLAGS-1:0] set_vec;
    logic                 err;
    logic                 agg_done;
    logic                 maa_done;
    logic                 unused_wbits;

    assign unused_wbits = ^{reg_wdata_i[REG_W-1:B_FLAGS+NUM_FLAGS],
                            reg_wdata_i[B_FLAGS-1:B_DSEL+1]};

    acsr_cfg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .wr        (reg_wr_i),
        .wbits     (reg_wdata_i[B_DSEL:0]),
        .cfg       (cfg),
        .flag_mode (flag_mode),
        .soft_rst  (soft_rst)
    );

    always_comb begin
        set_vec         = '0;
        set_vec[FL_CPH] = cph_done_i;
        set_vec[FL_HSH] = hsh_done_i;
        set_vec[FL_GLS] = gls_done_i;
        set_vec[FL_DMA] = dma_done_i;
    end

    acsr_flags #(.N(NUM_FLAGS)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .set_pulse (set_vec),
        .wr        (reg_wr_i),
        .wval      (reg_wdata_i[B_FLAGS +: NUM_FLAGS]),
        .w1c_mode  (flag_mode),
        .clr_all   (soft_rst),
        .flags     (flags)
    );

    assign maa_done = ~maa_stc_i;

    acsr_stat u_stat (
        .clk      (clk),
        .rst      (rst),
        .bus_err  (dma_bus_err_i),
        .soft_rst (soft_rst),
        .flags    (flags),
        .maa_done (maa_done),
        .dma_sel  (cfg.dma_sel),
        .irq_en   (cfg.irq_en),
        .err      (err),
        .agg_done (agg_done),
        .irq      (irq_o)
    );

    always_comb begin
        reg_rdata_o                          = cfg_pack(cfg);
        reg_rdata_o[B_RST]                   = soft_rst;
        reg_rdata_o[B_FMODE]                 = flag_mode;
        reg_rdata_o[B_MAA]                   = maa_done;
        reg_rdata_o[B_FLAGS +: NUM_FLAGS]    = flags;
        reg_rdata_o[B_ERR]                   = err;
        reg_rdata_o[B_RDY]                   = ~busy_i;
        reg_rdata_o[B_DONE]                  = agg_done;
    end

    assign soft_rst_o = soft_rst;
    assign dma_stop_o = err;
    assign src_sel_o  = cfg.src_sel;
    assign swap_in_o  = cfg.swap_in;
    assign swap_out_o = cfg.swap_out;
    assign wait_en_o  = cfg.wait_en;
    assign wait_pol_o = cfg.wait_pol;
    assign wr_src_o   = cfg.wr_src;
    assign rd_src_o   = cfg.rd_src;

endmodule

// File: rtl/acsr_chk.sv
module acsr_chk (
    input logic        clk,
    input logic        rst,
    input logic        soft_rst_o,
    input logic [31:0] reg_rdata_o,
    input logic        irq_o,
    input logic        dma_stop_o,
    input logic        dma_bus_err_i,
    input logic        cph_done_i
);

    // R1
    rst_pulse_one_chk: assert property (@(posedge clk) disable iff (rst)
        soft_rst_o |=> !soft_rst_o);

    // R5
    fmode_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata_o[11] && !soft_rst_o) |=> reg_rdata_o[11]);

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata_o[29] && !soft_rst_o) |=> reg_rdata_o[29]);

    // R7
    err_stop_chk: assert property (@(posedge clk) disable iff (rst)
        dma_bus_err_i |=> (dma_stop_o && reg_rdata_o[29]));

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        cph_done_i |=> reg_rdata_o[24]);

    // R9
    irq_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (reg_rdata_o[1] && (reg_rdata_o[31] || reg_rdata_o[29])));

endmodule

bind acsr_top acsr_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .soft_rst_o    (soft_rst_o),
    .reg_rdata_o   (reg_rdata_o),
    .irq_o         (irq_o),
    .dma_stop_o    (dma_stop_o),
    .dma_bus_err_i (dma_bus_err_i),
    .cph_done_i    (cph_done_i)
);

// File: tb/sim_acsr_top.sv
`timescale 1ns/1ps
module sim_acsr_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr;
    logic [31:0] wd;
    logic [31:0] rd;
    logic        cph, hsh, gls, dma, maa_stc, berr, busy;
    logic        srst, irq, dstop, srcs, swi, swo, wen, wpol;
    logic [1:0]  wrs, rds;

    int n_chk = 0;
    int n_err = 0;

    // bench model state
    logic        m_rst;
    logic [11:0] m_cfg;   // bits 12:1 of the word, bit 11 kept 0 here
    logic        m_fm;
    logic [3:0]  m_fl;
    logic        m_err;

    always #2.5 clk = ~clk;

    acsr_top u0 (
        .clk(clk), .rst(rst), .reg_wr_i(wr), .reg_wdata_i(wd), .reg_rdata_o(rd),
        .cph_done_i(cph), .hsh_done_i(hsh), .gls_done_i(gls), .dma_done_i(dma),
        .maa_stc_i(maa_stc), .dma_bus_err_i(berr), .busy_i(busy),
        .soft_rst_o(srst), .irq_o(irq), .dma_stop_o(dstop),
        .src_sel_o(srcs), .swap_in_o(swi), .swap_out_o(swo),
        .wait_en_o(wen), .wait_pol_o(wpol), .wr_src_o(wrs), .rd_src_o(rds)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic exp_done();
        return m_fl[0] | m_fl[1] | m_fl[2] | ~maa_stc | (m_fl[3] & m_cfg[11]);
    endfunction

    function automatic logic [31:0] exp_word();
        logic [31:0] w;
        w          = '0;
        w[0]       = m_rst;
        w[10:1]    = m_cfg[9:0];
        w[11]      = m_fm;
        w[12]      = m_cfg[11];
        w[23]      = ~maa_stc;
        w[27:24]   = m_fl;
        w[29]      = m_err;
        w[30]      = ~busy;
        w[31]      = exp_done();
        return w;
    endfunction

    task automatic compare_all();
        logic [31:0] e;
        e = exp_word();
        chk(rd[0] == e[0] && srst == m_rst, "R1", {31'b0, rd[0]}, {31'b0, e[0]});
        chk(rd[10:1] == e[10:1] && rd[12] == e[12], "R2", rd, e);
        chk({rds, wrs, wpol, wen, swi, swo, srcs} == e[10:2], "R2 pins",
            {23'b0, rds, wrs, wpol, wen, swi, swo, srcs}, {23'b0, e[10:2]});
        chk(rd[11] == e[11], "R5", {31'b0, rd[11]}, {31'b0, e[11]});
        chk(rd[27:24] == e[27:24], m_fm ? "R4" : "R3", {28'b0, rd[27:24]}, {28'b0, e[27:24]});
        chk(rd[29] == e[29] && dstop == m_err, "R7", {31'b0, rd[29]}, {31'b0, e[29]});
        chk(rd[31] == e[31], "R8", {31'b0, rd[31]}, {31'b0, e[31]});
        chk(irq == (m_cfg[0] & (e[31] | m_err)), "R9", {31'b0, irq},
            {31'b0, m_cfg[0] & (e[31] | m_err)});
        chk(rd[23] == e[23], "R10", {31'b0, rd[23]}, {31'b0, e[23]});
        chk(rd[30] == e[30] && rd[28] == 1'b0 && rd[22:13] == '0, "R11", rd, e);
    endtask

    // one clock: drive on the falling edge, model at the rising edge, compare at the next falling edge
    task automatic cyc(input logic w, input logic [31:0] d, input logic [3:0] set,
                       input logic be, input logic ms, input logic by);
        logic       n_rst, n_fm, n_err;
        logic [3:0] n_fl;
        wr = w; wd = d; cph = set[0]; hsh = set[1]; gls = set[2]; dma = set[3];
        berr = be; maa_stc = ms; busy = by;
        @(posedge clk);
        n_rst = w & d[0] & ~m_rst;
        for (int i = 0; i < 4; i++) begin
            if (set[i])      n_fl[i] = 1'b1;
            else if (m_rst)  n_fl[i] = 1'b0;
            else if (w)      n_fl[i] = m_fm ? (m_fl[i] & ~d[24+i]) : d[24+i];
            else             n_fl[i] = m_fl[i];
        end
        n_err = be ? 1'b1 : (m_rst ? 1'b0 : m_err);
        n_fm  = m_rst ? 1'b0 : ((w & d[11]) ? 1'b1 : m_fm);
        if (w) m_cfg = {d[12], 1'b0, d[10:1]};
        m_rst = n_rst; m_fl = n_fl; m_err = n_err; m_fm = n_fm;
        @(negedge clk);
        compare_all();
        wr = 1'b0; cph = 0; hsh = 0; gls = 0; dma = 0; berr = 0;
    endtask

    task automatic idle(input logic ms);
        cyc(1'b0, 32'h0, 4'h0, 1'b0, ms, 1'b0);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst = 1'b1; wr = 0; wd = '0; cph = 0; hsh = 0; gls = 0; dma = 0;
        berr = 0; maa_stc = 1'b1; busy = 1'b0;
        m_rst = 0; m_cfg = '0; m_fm = 0; m_fl = '0; m_err = 0;
        repeat (3) @(negedge clk);
        // R12: stored state is zero after hardware reset (maa_stc=1, busy=0)
        chk(rd == 32'h4000_0000, "R12", rd, 32'h4000_0000);
        rst = 1'b0;
        @(negedge clk);
        compare_all();

        // R3: direct writes in flag mode 0
        cyc(1, 32'h0A00_0002, 0, 0, 1, 0);
        cyc(1, 32'h0500_1002, 0, 0, 1, 0);
        // R8: DMA select off then on, DMA flag alone
        cyc(1, 32'h0800_0002, 0, 0, 1, 0);
        chk(rd[31] == 1'b0 && irq == 1'b0, "R8 dma excluded", rd, 32'h0800_0002);
        cyc(1, 32'h0800_1002, 0, 0, 1, 0);
        chk(rd[31] == 1'b1 && irq == 1'b1, "R9 dma included", rd, 32'h8800_1002);
        // R10: write to bit 23 ignored, bit follows pin
        cyc(1, 32'h0080_0000, 0, 0, 1, 0);
        chk(rd[23] == 1'b0, "R10 write ignored", rd, 32'h0);
        idle(0);
        chk(rd[23] == 1'b1, "R10 pin low", rd, 32'h0080_0000);
        // R5: set flag mode, then try to clear it
        cyc(1, 32'h0F00_0802, 0, 0, 1, 0);
        cyc(1, 32'h0000_0002, 0, 0, 1, 0);
        chk(rd[11] == 1'b1 && rd[27:24] == 4'hF, "R5", rd, 32'h0F00_0802);
        // R4: write-1-to-clear
        cyc(1, 32'h0300_0002, 0, 0, 1, 0);
        chk(rd[27:24] == 4'hC, "R4", {28'b0, rd[27:24]}, 32'hC);
        // R6: pulse and clear in the same cycle, set wins
        cyc(1, 32'h0400_0002, 4'h4, 0, 1, 0);
        chk(rd[26] == 1'b1, "R6", {31'b0, rd[26]}, 32'h1);
        // R7: bus error, write cannot clear
        cyc(0, 0, 0, 1, 1, 0);
        cyc(1, 32'h2000_0002, 0, 0, 1, 0);
        chk(rd[29] == 1'b1 && dstop == 1'b1, "R7 write ignored", rd, 32'h2000_0000);
        // R1/R2: soft reset keeps configuration, clears status and flag mode
        cyc(1, 32'h0000_17FF, 0, 0, 1, 0);
        chk(srst == 1'b1, "R1 pulse", {31'b0, srst}, 32'h1);
        cyc(1, 32'h0000_17FF, 0, 0, 1, 0);
        chk(srst == 1'b0 && rd[29] == 1'b0 && rd[11] == 1'b0, "R1 self clear", rd, 32'h0000_17FE);
        chk(rd[10:1] == 10'h3FF && rd[12] == 1'b1, "R2 kept", rd, 32'h0000_17FE);
        // R7: error pulse during soft reset wins
        cyc(1, 32'h0000_0001, 0, 0, 1, 0);
        cyc(0, 0, 0, 1, 1, 0);
        chk(rd[29] == 1'b1, "R7 set wins", {31'b0, rd[29]}, 32'h1);
        cyc(1, 32'h0000_0001, 0, 0, 1, 0);
        idle(1);

        // constrained random
        for (int k = 0; k < 4000; k++) begin
            logic [31:0] d;
            logic        w;
            d = $urandom();
            if (($urandom() % 16) != 0) d[0] = 1'b0;
            w = (($urandom() % 4) == 0);
            cyc(w, d, 4'($urandom() & $urandom()), (($urandom() % 64) == 0),
                (($urandom() % 4) != 0), 1'($urandom()));
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule